// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits on the host side of a configuration bus and gives software two ports for reaching device configuration registers. One port is a 32-bit address register. Software loads it with an enable flag, a bus number, a device/function number and a register offset. The other port is a data window. Reads and writes of one to four bytes through that window become single transactions on the downstream configuration bus, aimed at whatever the address register points to.

Upstream, a request is accepted when `up_valid` is high and `up_ready` is high. One cycle later or more, the block answers with a single-cycle `up_rsp_valid` pulse that carries `up_rdata`. Downstream, a request is held with `dn_valid` until `dn_ready` is seen. The device then answers with `dn_rsp_valid`, and `dn_present` says whether anything decoded the address.

The controller has four named states: `ST_IDLE`, `ST_ISSUE`, `ST_WAIT` and `ST_REPLY`. Its transitions are as follows.
- Idle→Reply is taken for an address-port access, or for a data-port access while the enable bit is clear.
- Idle→Issue is taken for an enabled data-port access.
- Issue→Wait is taken on `dn_ready`.
- Wait→Reply is taken on `dn_rsp_valid`.
- Reply→Idle is taken unconditionally.

A parameter selects byte ordering.

Top module: `cfg_bridge`

## Requirements
- R1: After reset the address register reads 0. A write to the address port (`up_sel`=0) stores all 32 bits, and a read of the address port returns the stored value unchanged.
- R2: While bit 31 of the address register is 0, a data-port read (`up_sel`=1) returns 0xFFFFFFFF, a data-port write is dropped, and neither produces a downstream request.
- R3: Downstream `dn_bus` is address-register bits 23:16 and `dn_devfn` is bits 15:8.
- R4: `dn_off` is address-register bits 7:0 ORed with `up_byte`, masked to the configuration-space size (default 256 bytes).
- R5: `dn_len` is the smaller of the requested length (`up_len`+1, since `up_len` encodes length minus one) and the space size minus `dn_off`, so no access passes the end of the space.
- R6: When the device answers with `dn_present`=0, a read returns 0xFFFFFFFF.
- R7: Write data goes downstream right-aligned, with bytes beyond `dn_len` zeroed. Read data comes back right-aligned, with bytes beyond `dn_len` zeroed. A write response carries 0.
- R8: `dn_be` is a mask of `dn_len` ones, shifted left by `dn_off[1:0]`, over 8 lanes.
- R9: `dn_valid` and its fields stay stable until `dn_ready`. Only one transaction is outstanding at a time. `up_ready` is low from acceptance until the response has been given, and each access gets exactly one `up_rsp_valid` pulse.
- R10: With BIG_ENDIAN=1, upstream values are byte-reversed. For the address port the reversal spans all 4 bytes. For the data port it spans the access length: write data is reversed over the requested length, and read data is reversed over `dn_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream access request |
| up_ready | output | 1 | Bridge can accept a request |
| up_sel | input | 1 | 0 = address port, 1 = data port |
| up_we | input | 1 | 1 = write, 0 = read |
| up_byte | input | 2 | Byte address within the data port |
| up_len | input | 2 | Access length minus one |
| up_wdata | input | 32 | Upstream write data, right-aligned |
| up_rsp_valid | output | 1 | One-cycle response strobe |
| up_rdata | output | 32 | Response data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_we | output | 1 | Downstream write |
| dn_bus | output | 8 | Target bus number |
| dn_devfn | output | 8 | Target device/function |
| dn_off | output | OFF_W | Register offset |
| dn_len | output | 3 | Clipped length in bytes |
| dn_be | output | 8 | Lane byte enables |
| dn_wdata | output | 32 | Write data, right-aligned |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_present | input | 1 | A device decoded the access |
| dn_rdata | input | 32 | Read data from the device |

## Verification
The data window is driven in several ways.
- Aligned full-word reads, which separate a wrong field split from a correct one.
- Accesses at byte addresses 1, 2 and 3, which show whether the byte address is merged into the offset and the lane enables.
- Four-byte accesses at offsets 0xFC, 0xFE and 0xFF, which show whether clipping at the end of the space works.
- A reference device that fills unused upper bytes with junk, so missing masking shows up.
- An absent device that returns zero, which must still read as all ones.
- A disabled window, a stalling `dn_ready`, and a second instance with reversed byte order.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

    localparam int WORD_W    = 32;
    localparam int EN_BIT    = 31;
    localparam int BUS_LSB   = 16;
    localparam int BUS_W     = 8;
    localparam int DEVFN_LSB = 8;
    localparam int DEVFN_W   = 8;
    localparam int LANES     = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_REPLY
    } br_state_e;

    // keep the low n bytes of v, zero the rest
    function automatic logic [WORD_W-1:0] keep_bytes(input logic [WORD_W-1:0] v,
                                                     input logic [2:0] n);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < int'(n)) r[8*i +: 8] = v[8*i +: 8];
        end
        return r;
    endfunction

    // reverse the order of the low n bytes of v, zero the rest
    function automatic logic [WORD_W-1:0] flip_bytes(input logic [WORD_W-1:0] v,
                                                     input logic [2:0] n);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                if (i < int'(n) && j == int'(n) - 1 - i) r[8*i +: 8] = v[8*j +: 8];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

    // R1: a write lands whole in the register
    p_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q == $past(wr_data));

endmodule

// File: rtl/cfg_access_calc.sv
module cfg_access_calc
    import cfg_bridge_pkg::*;
#(
    parameter int SPACE = 256,
    parameter int OFF_W = $clog2(SPACE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  addr_q,
    input  logic [1:0]         byte_sel,
    input  logic [1:0]         len_m1,
    output logic [BUS_W-1:0]   bus,
    output logic [DEVFN_W-1:0] devfn,
    output logic [OFF_W-1:0]   off,
    output logic [2:0]         len_eff,
    output logic [LANES-1:0]   be
);

    localparam logic [OFF_W:0] SPACE_V = (OFF_W+1)'(SPACE);

    logic [WORD_W-1:0] composed;
    logic [OFF_W:0]    room;
    logic [2:0]        req_len;
    logic [LANES-1:0]  len_mask;

    always_comb begin
        composed = addr_q | {{(WORD_W-2){1'b0}}, byte_sel};
        bus      = composed[BUS_LSB +: BUS_W];
        devfn    = composed[DEVFN_LSB +: DEVFN_W];
        off      = composed[OFF_W-1:0];
        room     = SPACE_V - {1'b0, off};
        req_len  = {1'b0, len_m1} + 3'd1;
        if ((OFF_W+1)'(req_len) < room) begin
            len_eff = req_len;
        end else begin
            len_eff = room[2:0];
        end
        unique case (len_eff)
            3'd1:    len_mask = 8'h01;
            3'd2:    len_mask = 8'h03;
            3'd3:    len_mask = 8'h07;
            3'd4:    len_mask = 8'h0F;
            default: len_mask = 8'h00;
        endcase
        be = len_mask << off[1:0];
    end

    // R5: the access never runs past the end of the space
    p_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((OFF_W+2)'(off) + (OFF_W+2)'(len_eff) <= (OFF_W+2)'(SPACE)) && len_eff != 3'd0);

    // R8: lane enables count exactly the clipped bytes
    p_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(be) == int'(len_eff));

endmodule

// File: rtl/cfg_bridge_fsm.sv
module cfg_bridge_fsm
    import cfg_bridge_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_sel,
    input  logic              up_we,
    input  logic [1:0]        up_byte,
    input  logic [1:0]        up_len,
    input  logic [WORD_W-1:0] up_wdata,
    output logic              up_rsp_valid,
    output logic [WORD_W-1:0] up_rdata,
    input  logic [WORD_W-1:0] addr_q,
    input  logic [2:0]        len_eff,
    output logic              addr_wr_en,
    output logic [WORD_W-1:0] addr_wr_data,
    output logic [1:0]        req_byte,
    output logic [1:0]        req_len_m1,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_we,
    output logic [WORD_W-1:0] dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic              dn_present,
    input  logic [WORD_W-1:0] dn_rdata
);

    br_state_e         state, nxt;
    logic              accept;
    logic              en;
    logic              req_we;
    logic [WORD_W-1:0] req_wdata;
    logic [WORD_W-1:0] rsp_data;
    logic [2:0]        req_len;
    logic [WORD_W-1:0] addr_view;
    logic [WORD_W-1:0] wr_shaped;
    logic [WORD_W-1:0] rd_shaped;
    logic [WORD_W-1:0] up_addr_in;

    assign en      = addr_q[EN_BIT];
    assign accept  = (state == ST_IDLE) && up_valid;
    assign req_len = {1'b0, req_len_m1} + 3'd1;

    generate
        if (BIG_ENDIAN) begin : g_swap
            assign up_addr_in = flip_bytes(up_wdata, 3'd4);
            assign addr_view  = flip_bytes(addr_q, 3'd4);
            assign wr_shaped  = keep_bytes(flip_bytes(req_wdata, req_len), len_eff);
            assign rd_shaped  = flip_bytes(keep_bytes(dn_rdata, len_eff), len_eff);
        end else begin : g_plain
            assign up_addr_in = up_wdata;
            assign addr_view  = addr_q;
            assign wr_shaped  = keep_bytes(req_wdata, len_eff);
            assign rd_shaped  = keep_bytes(dn_rdata, len_eff);
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!up_sel || !en) nxt = ST_REPLY;
                    else                nxt = ST_ISSUE;
                end
            end
            ST_ISSUE: if (dn_ready)     nxt = ST_WAIT;
            ST_WAIT:  if (dn_rsp_valid) nxt = ST_REPLY;
            ST_REPLY:                   nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        up_ready     = (state == ST_IDLE);
        dn_valid     = (state == ST_ISSUE);
        up_rsp_valid = (state == ST_REPLY);
        addr_wr_en   = accept && !up_sel && up_we;
        addr_wr_data = up_addr_in;
        dn_we        = req_we;
        dn_wdata     = wr_shaped;
        up_rdata     = rsp_data;
    end

    // request capture and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we     <= 1'b0;
            req_byte   <= '0;
            req_len_m1 <= '0;
            req_wdata  <= '0;
            rsp_data   <= '0;
        end else begin
            if (accept) begin
                req_we     <= up_we;
                req_byte   <= up_byte;
                req_len_m1 <= up_len;
                req_wdata  <= up_wdata;
                if (up_we)        rsp_data <= '0;
                else if (!up_sel) rsp_data <= addr_view;
                else              rsp_data <= '1;
            end
            if (state == ST_WAIT && dn_rsp_valid) begin
                if (req_we)          rsp_data <= '0;
                else if (dn_present) rsp_data <= rd_shaped;
                else                 rsp_data <= '1;
            end
        end
    end

    // R9: each access is answered by a single pulse
    p_one_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |=> !up_rsp_valid);

    // R9: no new upstream request while a downstream one is open
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !up_ready);

    // R2: a disabled data read returns all ones without going downstream
    p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && up_sel && !en && !up_we) |=> (up_rsp_valid && !dn_valid && up_rdata == '1));

    // R6: an absent device reads as all ones
    p_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && dn_rsp_valid && !dn_present && !req_we) |=> up_rdata == '1);

endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int SPACE      = 256,
    parameter bit BIG_ENDIAN = 1'b0,
    parameter int OFF_W      = $clog2(SPACE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_valid,
    output logic               up_ready,
    input  logic               up_sel,
    input  logic               up_we,
    input  logic [1:0]         up_byte,
    input  logic [1:0]         up_len,
    input  logic [31:0]        up_wdata,
    output logic               up_rsp_valid,
    output logic [31:0]        up_rdata,
    output logic               dn_valid,
    input  logic               dn_ready,
    output logic               dn_we,
    output logic [7:0]         dn_bus,
    output logic [7:0]         dn_devfn,
    output logic [OFF_W-1:0]   dn_off,
    output logic [2:0]         dn_len,
    output logic [7:0]         dn_be,
    output logic [31:0]        dn_wdata,
    input  logic               dn_rsp_valid,
    input  logic               dn_present,
    input  logic [31:0]        dn_rdata
);

    logic [WORD_W-1:0] addr_q;
    logic              addr_wr_en;
    logic [WORD_W-1:0] addr_wr_data;
    logic [1:0]        req_byte;
    logic [1:0]        req_len_m1;

    cfg_addr_reg u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_wr_en),
        .wr_data (addr_wr_data),
        .q       (addr_q)
    );

    cfg_access_calc #(.SPACE(SPACE), .OFF_W(OFF_W)) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_q   (addr_q),
        .byte_sel (req_byte),
        .len_m1   (req_len_m1),
        .bus      (dn_bus),
        .devfn    (dn_devfn),
        .off      (dn_off),
        .len_eff  (dn_len),
        .be       (dn_be)
    );

    cfg_bridge_fsm #(.BIG_ENDIAN(BIG_ENDIAN)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_valid     (up_valid),
        .up_ready     (up_ready),
        .up_sel       (up_sel),
        .up_we        (up_we),
        .up_byte      (up_byte),
        .up_len       (up_len),
        .up_wdata     (up_wdata),
        .up_rsp_valid (up_rsp_valid),
        .up_rdata     (up_rdata),
        .addr_q       (addr_q),
        .len_eff      (dn_len),
        .addr_wr_en   (addr_wr_en),
        .addr_wr_data (addr_wr_data),
        .req_byte     (req_byte),
        .req_len_m1   (req_len_m1),
        .dn_valid     (dn_valid),
        .dn_ready     (dn_ready),
        .dn_we        (dn_we),
        .dn_wdata     (dn_wdata),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_present   (dn_present),
        .dn_rdata     (dn_rdata)
    );

    // R9: an open request holds still until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_off) && $stable(dn_bus)
                                     && $stable(dn_devfn) && $stable(dn_wdata) && $stable(dn_len)));

endmodule

// File: tb/tb_cfg_bridge.sv
`timescale 1ns/1ps
module tb_cfg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0, up_sel = 1'b0, up_we = 1'b0;
    logic [1:0]  up_byte = '0, up_len = '0;
    logic [31:0] up_wdata = '0, be_wdata = '0;
    logic        up_ready, up_rsp_valid, dn_valid, dn_we;
    logic [31:0] up_rdata, dn_wdata;
    logic [7:0]  dn_bus, dn_devfn, dn_off, dn_be;
    logic [2:0]  dn_len;
    logic        dn_ready, dn_rsp_valid = 1'b0, dn_present = 1'b0;
    logic [31:0] dn_rdata = '0;

    logic        b_up_ready, b_rsp_valid, b_dn_valid, b_dn_we;
    logic [31:0] b_up_rdata, b_dn_wdata;
    logic [7:0]  b_dn_bus, b_dn_devfn, b_dn_off, b_dn_be;
    logic [2:0]  b_dn_len;
    logic        b_rsp = 1'b0;
    logic [31:0] b_last_wdata = '0, b_last_rdata = '0;

    int          checks = 0, errors = 0, dn_cnt = 0;
    logic        slow = 1'b0, rdy_t = 1'b1;
    logic [7:0]  last_bus, last_devfn, last_off, last_be;
    logic [2:0]  last_len;
    logic [31:0] last_wdata;
    logic [7:0]  dev_mem [2][256];
    logic [7:0]  ref_mem [2][256];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;   // 125 MHz
    assign dn_ready = slow ? rdy_t : 1'b1;

    cfg_bridge dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_sel(up_sel), .up_we(up_we), .up_byte(up_byte), .up_len(up_len),
        .up_wdata(up_wdata), .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_we(dn_we), .dn_bus(dn_bus),
        .dn_devfn(dn_devfn), .dn_off(dn_off), .dn_len(dn_len), .dn_be(dn_be),
        .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid), .dn_present(dn_present),
        .dn_rdata(dn_rdata)
    );

    cfg_bridge #(.BIG_ENDIAN(1'b1)) dut_be (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(b_up_ready),
        .up_sel(up_sel), .up_we(up_we), .up_byte(up_byte), .up_len(up_len),
        .up_wdata(be_wdata), .up_rsp_valid(b_rsp_valid), .up_rdata(b_up_rdata),
        .dn_valid(b_dn_valid), .dn_ready(1'b1), .dn_we(b_dn_we), .dn_bus(b_dn_bus),
        .dn_devfn(b_dn_devfn), .dn_off(b_dn_off), .dn_len(b_dn_len), .dn_be(b_dn_be),
        .dn_wdata(b_dn_wdata), .dn_rsp_valid(b_rsp), .dn_present(1'b1),
        .dn_rdata(32'hEEEE_BBAA)
    );

    function automatic int find_dev(input logic [7:0] bus, input logic [7:0] dfn);
        if (bus == 8'h00 && dfn == 8'h08) return 0;
        if (bus == 8'h03 && dfn == 8'h11) return 1;
        return -1;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] v, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
        return r;
    endfunction

    function automatic int clip(input int off, input int len);
        return (len < 256 - off) ? len : 256 - off;
    endfunction

    function automatic logic [31:0] exp_read(input int idx, input int off, input int len);
        logic [31:0] r = '0;
        if (idx < 0) return 32'hFFFF_FFFF;
        for (int i = 0; i < clip(off, len); i++) r[8*i +: 8] = ref_mem[idx][off+i];
        return r;
    endfunction

    task automatic ref_write(input int idx, input int off, input int len, input logic [31:0] wd);
        for (int i = 0; i < clip(off, len); i++) ref_mem[idx][off+i] = wd[8*i +: 8];
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // downstream device model
    always @(posedge clk) begin
        int idx;
        logic [31:0] rd;
        dn_rsp_valid <= 1'b0;
        rdy_t <= ~rdy_t;
        b_rsp <= b_dn_valid;
        if (b_dn_valid) b_last_wdata <= b_dn_wdata;
        if (!rst_n) begin
            for (int d = 0; d < 2; d++)
                for (int a = 0; a < 256; a++) dev_mem[d][a] <= 8'(a ^ (d * 8'h5A));
        end else if (dn_valid && dn_ready) begin
            dn_cnt     <= dn_cnt + 1;
            last_bus   <= dn_bus;
            last_devfn <= dn_devfn;
            last_off   <= dn_off;
            last_len   <= dn_len;
            last_be    <= dn_be;
            last_wdata <= dn_wdata;
            idx = find_dev(dn_bus, dn_devfn);
            rd  = 32'hEEEE_EEEE;
            if (idx >= 0) begin
                for (int i = 0; i < 4; i++) begin
                    if (i < int'(dn_len)) begin
                        rd[8*i +: 8] = dev_mem[idx][int'(dn_off) + i];
                        if (dn_we) dev_mem[idx][int'(dn_off) + i] <= dn_wdata[8*i +: 8];
                    end
                end
            end else begin
                rd = 32'h0;
            end
            dn_rsp_valid <= 1'b1;
            dn_present   <= (idx >= 0);
            dn_rdata     <= rd;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && up_rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected response", up_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(up_rdata === e, t, up_rdata, e);
            end
        end
        if (rst_n && b_rsp_valid) b_last_rdata <= b_up_rdata;
    end

    task automatic access(input logic sel, input logic we, input logic [1:0] bs, input int len,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!up_ready) @(negedge clk);
        up_valid = 1'b1; up_sel = sel; up_we = we; up_byte = bs;
        up_len = 2'(len - 1); up_wdata = wd;
        be_wdata = rev(wd, sel ? len : 4);
        @(negedge clk);
        up_valid = 1'b0;
        chk(up_ready == 1'b0, "R9 busy after accept", 32'(up_ready), 32'h0);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_addr(input logic [31:0] a);
        access(1'b0, 1'b1, 2'd0, 4, a, 32'h0, "R1 address write");
    endtask

    initial begin
        int n0;
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 256; a++) ref_mem[d][a] = 8'(a ^ (d * 8'h5A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(up_ready === 1'b1 && dn_valid === 1'b0 && up_rsp_valid === 1'b0,
            "R9 idle after reset", {29'b0, up_ready, dn_valid, up_rsp_valid}, 32'h4);

        access(1'b0, 1'b0, 2'd0, 4, 32'h0, 32'h0, "R1 reset value");
        access(1'b1, 1'b0, 2'd0, 4, 32'h0, 32'hFFFF_FFFF, "R2 disabled read");
        n0 = dn_cnt;
        access(1'b1, 1'b1, 2'd0, 4, 32'h1122_3344, 32'h0, "R2 disabled write");
        chk(dn_cnt == n0, "R2 no downstream", 32'(dn_cnt), 32'(n0));

        set_addr(32'h1234_5678);
        access(1'b0, 1'b0, 2'd0, 4, 32'h0, 32'h1234_5678, "R1 readback");

        set_addr(32'h8000_0810);
        access(1'b1, 1'b0, 2'd0, 4, 32'h0, exp_read(0, 16, 4), "R7 aligned read");
        chk(last_bus == 8'h00 && last_devfn == 8'h08, "R3 fields",
            {16'h0, last_bus, last_devfn}, 32'h0000_0008);
        chk(last_off == 8'h10, "R4 offset", 32'(last_off), 32'h10);

        access(1'b1, 1'b0, 2'd2, 2, 32'h0, exp_read(0, 18, 2), "R4 byte merge read");
        chk(last_off == 8'h12, "R4 merged offset", 32'(last_off), 32'h12);
        chk(last_be == 8'h0C, "R8 lanes at byte 2", 32'(last_be), 32'h0C);

        access(1'b1, 1'b1, 2'd1, 1, 32'hFFFF_FFA5, 32'h0, "R7 write response");
        ref_write(0, 17, 1, 32'hFFFF_FFA5);
        chk(last_wdata == 32'h0000_00A5, "R7 write data", last_wdata, 32'hA5);
        chk(last_be == 8'h02, "R8 lanes at byte 1", 32'(last_be), 32'h02);
        access(1'b1, 1'b0, 2'd0, 4, 32'h0, exp_read(0, 16, 4), "R7 readback");

        set_addr(32'h8003_11FC);
        access(1'b1, 1'b1, 2'd2, 4, 32'hAABB_CCDD, 32'h0, "R5 clipped write");
        ref_write(1, 8'hFE, 4, 32'hAABB_CCDD);
        chk(last_len == 3'd2, "R5 clipped length", 32'(last_len), 32'h2);
        chk(last_be == 8'h0C, "R8 clipped lanes", 32'(last_be), 32'h0C);
        access(1'b1, 1'b0, 2'd0, 4, 32'h0, exp_read(1, 8'hFC, 4), "R5 read to end");
        access(1'b1, 1'b0, 2'd3, 4, 32'h0, exp_read(1, 8'hFF, 4), "R5 R7 last byte");

        set_addr(32'h8005_0000);
        access(1'b1, 1'b0, 2'd0, 4, 32'h0, 32'hFFFF_FFFF, "R6 absent read");
        access(1'b1, 1'b1, 2'd0, 4, 32'h55, 32'h0, "R6 absent write");

        slow = 1'b1;
        set_addr(32'h8000_0820);
        access(1'b1, 1'b0, 2'd1, 2, 32'h0, exp_read(0, 8'h21, 2), "R9 stalled read");
        access(1'b1, 1'b1, 2'd0, 4, 32'hCAFE_F00D, 32'h0, "R9 stalled write");
        ref_write(0, 8'h20, 4, 32'hCAFE_F00D);
        access(1'b1, 1'b0, 2'd0, 4, 32'h0, exp_read(0, 8'h20, 4), "R9 stalled readback");
        slow = 1'b0;

        set_addr(32'h8000_0840);
        access(1'b1, 1'b1, 2'd0, 2, 32'h0000_1234, 32'h0, "R10 write main");
        ref_write(0, 8'h40, 2, 32'h0000_1234);
        chk(b_last_wdata == 32'h0000_1234, "R10 swapped write", b_last_wdata, 32'h1234);
        access(1'b1, 1'b0, 2'd0, 2, 32'h0, exp_read(0, 8'h40, 2), "R10 read main");
        chk(b_last_rdata == 32'h0000_AABB, "R10 swapped read", b_last_rdata, 32'hAABB);
        access(1'b0, 1'b0, 2'd0, 4, 32'h0, 32'h8000_0840, "R1 readback enabled");
        chk(b_last_rdata == 32'h4008_0080, "R10 address order", b_last_rdata, 32'h4008_0080);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule